// File: doc/BRIEF.md
# Rotating XOR Block Space Compactor

This block squeezes the outgoing bits of several scan chains into a few serial tester pins. Only the final cell of each chain feeds it. Each enabled shift cycle, every chain bit that is set XORs a fixed tap vector into a signature register that holds `N_OUTS*DEPTH` bits. The register also rotates right by one position each cycle. As a result, the check-matrix rows of one chain's cells within a block are cyclic shifts of that chain's tap vector.

After `DEPTH` enabled cycles the block is complete. The finished signature moves into a shadow register, and the signature register restarts from zero. While the next block is being compacted, the shadow register presents its signature on the tester pins, `N_OUTS` bits per cycle. Scan shifting therefore never stalls on signature unload. A diagnosis flow can recover error positions in each block by matching the observed signature against XORs of the check-matrix rows.

With the default taps, chain 0 has tap vector `01011` and chain 1 has `11100`, with depth 5 and one output. Every one of the ten rows has weight three, and no two rows are equal.

Top module: `rot_block_compactor`

## Requirements
- R1: While `rst` (active high, synchronous) is high, the signature register, shadow register and block phase are cleared. Right after reset, `tester_out` is 0 and `block_valid` is 0, and the signature unloaded during the first block is 0.
- R2: When `shift_en` is low, no state changes and `chain_bits` are ignored. `tester_out` holds its value and the pending block's signature is unaffected.
- R3: A block has W = N_OUTS*DEPTH signature bits. T_c = TAPS[c*W +: W] is the tap vector of chain c. A single 1 on chain c in enabled cycle t of a block (t counted from 0) gives a signature equal to T_c rotated right (D-1-t) times. One right rotation moves bit 0 to bit W-1.
- R4: The signature of a block with several set bits is the XOR of their single-bit signatures.
- R5: The signature register is cleared at every block boundary, so a block's signature depends only on that block's inputs.
- R6: `block_valid` is high exactly in enabled cycle D-1 of each block, and only while `shift_en` is high. It marks the cycle whose closing edge loads the shadow register.
- R7: During enabled cycle j of the next block, `tester_out` equals bits `[j*N_OUTS +: N_OUTS]` of the previous block's signature, so the least significant slice comes first.
- R8: Blocks follow each other with no idle cycle. Each block's signature is unloaded in full while the next block is compacted.
- R9: With the default taps, the ten single-bit signatures are all nonzero, all distinct and all of weight three.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| shift_en | input | 1 | Advances compaction, phase and unload when high |
| chain_bits | input | N_CHAINS | Final-stage bit of each scan chain |
| tester_out | output | N_OUTS | Serial signature slice toward the tester |
| block_valid | output | 1 | High in the cycle whose edge loads the shadow register |

## Verification
The bench tries all 1024 error patterns of one 2-chain, depth-5 block, run back to back. The single-bit patterns pin each check-matrix row, and therefore the rotation direction and the tap-to-chain mapping. The multi-bit patterns show whether XOR linearity holds. The all-zero block after the all-ones block exposes any leftover signature state. Stalls with every chain input forced to 1 inside chosen blocks separate true gating from partial gating. A reset in the middle of a run shows whether the shadow register and the phase restart together.

// File: rtl/rbc_pkg.sv
package rbc_pkg;

    localparam int unsigned DEF_CHAINS = 2;
    localparam int unsigned DEF_OUTS   = 1;
    localparam int unsigned DEF_DEPTH  = 5;
    // chain 0 in the low bits, chain 1 above it
    localparam logic [DEF_CHAINS*DEF_OUTS*DEF_DEPTH-1:0] DEF_TAPS = 10'b11100_01011;

    typedef struct packed {
        logic step;   // an enabled shift cycle
        logic last;   // enabled cycle that closes the block
    } phase_t;

    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/rbc_phase_ctr.sv
module rbc_phase_ctr
    import rbc_pkg::*;
#(
    parameter int unsigned DEPTH = DEF_DEPTH
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   shift_en,
    output phase_t phase
);
    localparam int unsigned CW = cnt_width(DEPTH);
    localparam logic [CW-1:0] LAST = CW'(DEPTH - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (shift_en) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
        end
    end

    always_comb begin
        phase.step = shift_en;
        phase.last = shift_en && (cnt_q == LAST);
    end
endmodule

// File: rtl/rbc_xor_net.sv
module rbc_xor_net #(
    parameter int unsigned N_CHAINS = 2,
    parameter int unsigned W        = 5,
    parameter logic [N_CHAINS*W-1:0] TAPS = '0
) (
    input  logic [W-1:0]        comp_q,
    input  logic [N_CHAINS-1:0] bits,
    output logic [W-1:0]        comp_nxt
);
    logic [W-1:0] acc [N_CHAINS+1];

    generate
        if (W > 1) begin : g_rot
            assign acc[0] = {comp_q[0], comp_q[W-1:1]};
        end else begin : g_norot
            assign acc[0] = comp_q;
        end
        for (genvar c = 0; c < N_CHAINS; c++) begin : g_chain
            assign acc[c+1] = acc[c] ^ ({W{bits[c]}} & TAPS[c*W +: W]);
        end
    endgenerate

    assign comp_nxt = acc[N_CHAINS];
endmodule

// File: rtl/rbc_shadow.sv
module rbc_shadow
    import rbc_pkg::*;
#(
    parameter int unsigned N_OUTS = DEF_OUTS,
    parameter int unsigned DEPTH  = DEF_DEPTH,
    localparam int unsigned W     = N_OUTS * DEPTH
) (
    input  logic              clk,
    input  logic              rst,
    input  phase_t            phase,
    input  logic [W-1:0]      sig_in,
    output logic [N_OUTS-1:0] ser_out
);
    logic [W-1:0] sh_q;
    logic [W-1:0] sh_shift;

    generate
        if (DEPTH > 1) begin : g_shift
            assign sh_shift = {{N_OUTS{1'b0}}, sh_q[W-1:N_OUTS]};
        end else begin : g_single
            assign sh_shift = '0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '0;
        end else if (phase.last) begin
            sh_q <= sig_in;
        end else if (phase.step) begin
            sh_q <= sh_shift;
        end
    end

    assign ser_out = sh_q[N_OUTS-1:0];
endmodule

// File: rtl/rot_block_compactor.sv
module rot_block_compactor
    import rbc_pkg::*;
#(
    parameter int unsigned N_CHAINS = DEF_CHAINS,
    parameter int unsigned N_OUTS   = DEF_OUTS,
    parameter int unsigned DEPTH    = DEF_DEPTH,
    parameter logic [N_CHAINS*N_OUTS*DEPTH-1:0] TAPS = DEF_TAPS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                shift_en,
    input  logic [N_CHAINS-1:0] chain_bits,
    output logic [N_OUTS-1:0]   tester_out,
    output logic                block_valid
);
    localparam int unsigned W = N_OUTS * DEPTH;

    phase_t       phase;
    logic [W-1:0] comp_q;
    logic [W-1:0] comp_nxt;

    rbc_phase_ctr #(.DEPTH(DEPTH)) phase_i (
        .clk      (clk),
        .rst      (rst),
        .shift_en (shift_en),
        .phase    (phase)
    );

    rbc_xor_net #(.N_CHAINS(N_CHAINS), .W(W), .TAPS(TAPS)) xor_i (
        .comp_q   (comp_q),
        .bits     (chain_bits),
        .comp_nxt (comp_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            comp_q <= '0;
        end else if (phase.last) begin
            comp_q <= '0;
        end else if (phase.step) begin
            comp_q <= comp_nxt;
        end
    end

    rbc_shadow #(.N_OUTS(N_OUTS), .DEPTH(DEPTH)) shadow_i (
        .clk     (clk),
        .rst     (rst),
        .phase   (phase),
        .sig_in  (comp_nxt),
        .ser_out (tester_out)
    );

    assign block_valid = phase.last;
endmodule

// File: rtl/rbc_checker.sv
module rbc_checker
    import rbc_pkg::*;
#(
    parameter int unsigned N_CHAINS = DEF_CHAINS,
    parameter int unsigned N_OUTS   = DEF_OUTS,
    parameter int unsigned DEPTH    = DEF_DEPTH,
    localparam int unsigned W       = N_OUTS * DEPTH
) (
    input logic                clk,
    input logic                rst,
    input logic                shift_en,
    input logic                block_valid,
    input logic [N_OUTS-1:0]   tester_out,
    input logic [W-1:0]        comp_q
);
    localparam int unsigned CW = cnt_width(DEPTH);

    // independent count of enabled cycles within the current block
    logic [CW-1:0] seen_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= '0;
        end else if (shift_en) begin
            seen_q <= (seen_q == CW'(DEPTH - 1)) ? '0 : seen_q + CW'(1);
        end
    end

    a_r1_reset_out_zero: assert property (@(posedge clk)
        rst |=> (tester_out == '0));

    a_r2_hold_out: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(tester_out));

    a_r2_hold_sig: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(comp_q));

    a_r5_clear_after_block: assert property (@(posedge clk) disable iff (rst)
        block_valid |=> (comp_q == '0));

    a_r6_valid_gated: assert property (@(posedge clk) disable iff (rst)
        block_valid |-> shift_en);

    a_r6_valid_period: assert property (@(posedge clk) disable iff (rst)
        shift_en |-> (block_valid == (seen_q == CW'(DEPTH - 1))));
endmodule

bind rot_block_compactor rbc_checker #(
    .N_CHAINS (N_CHAINS),
    .N_OUTS   (N_OUTS),
    .DEPTH    (DEPTH)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .shift_en    (shift_en),
    .block_valid (block_valid),
    .tester_out  (tester_out),
    .comp_q      (comp_q)
);

// File: tb/rot_block_compactor_tb_top.sv
module rot_block_compactor_tb_top;
    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned NC = 2;
    localparam int unsigned NO = 1;
    localparam int unsigned D  = 5;
    localparam int unsigned W  = NO * D;
    localparam int unsigned NB = NC * D;
    localparam logic [NC*W-1:0] TAPS_TB = 10'b11100_01011;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          shift_en = 1'b0;
    logic [NC-1:0] chain_bits = '0;
    logic [NO-1:0] tester_out;
    logic          block_valid;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rot_block_compactor #(
        .N_CHAINS (NC), .N_OUTS (NO), .DEPTH (D), .TAPS (TAPS_TB)
    ) dut_i (
        .clk (clk), .rst (rst), .shift_en (shift_en),
        .chain_bits (chain_bits), .tester_out (tester_out),
        .block_valid (block_valid)
    );

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] rotr(input logic [W-1:0] v, input int k);
        logic [W-1:0] r = v;
        for (int i = 0; i < k; i++) r = {r[0], r[W-1:1]};
        return r;
    endfunction

    function automatic logic [W-1:0] exp_sig(input logic [NB-1:0] pat);
        logic [W-1:0] s = '0;
        for (int t = 0; t < D; t++)
            for (int c = 0; c < NC; c++)
                if (pat[t*NC + c]) s ^= rotr(TAPS_TB[c*W +: W], D - 1 - t);
        return s;
    endfunction

    // drives one block; collects the previous block's signature
    task automatic run_block(input logic [NB-1:0] pat, input int stall_at,
                             output logic [W-1:0] got);
        got = '0;
        for (int j = 0; j < D; j++) begin
            @(negedge clk);
            got[j*NO +: NO] = tester_out;
            if (j == stall_at) begin
                shift_en = 1'b0;
                chain_bits = '1;
                #1;
                check(block_valid == 1'b0, "R2 valid while stalled", block_valid, 0);
                for (int k = 0; k < 3; k++) begin
                    @(negedge clk);
                    check(tester_out == got[j*NO +: NO], "R2 output held",
                          tester_out, got[j*NO +: NO]);
                end
            end
            shift_en = 1'b1;
            chain_bits = pat[j*NC +: NC];
            #1;
            check(block_valid == (j == D - 1), "R6 block_valid phase",
                  block_valid, (j == D - 1));
        end
    endtask

    initial begin
        logic [W-1:0] got;
        logic [W-1:0] prev;
        string tag;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check(tester_out == '0, "R1 out after reset", tester_out, 0);
        check(block_valid == 1'b0, "R1 valid after reset", block_valid, 0);

        prev = '0;
        for (int p = 0; p < (1 << NB); p++) begin
            run_block(NB'(p), (p % 97 == 5) ? (p % D) : -1, got);
            check(got == prev, "R3 R4 R8 sweep signature", got, prev);
            prev = exp_sig(NB'(p));
            if ($countones(NB'(p)) == 1) begin
                tag = "R3 single error";
            end else begin
                tag = (p == 0) ? "R5 empty block" : "R4 multi error";
            end
            if ($countones(NB'(p)) == 1)
                check($countones(prev) == 3, "R9 row weight", $countones(prev), 3);
            if (p > 0 && p < 4) check(prev != '0, tag, prev, 1);
        end
        run_block('0, -1, got);
        check(got == prev, "R3 R4 last sweep block", got, prev);

        // R9: all single rows distinct
        for (int a = 0; a < NB; a++)
            for (int b = a + 1; b < NB; b++)
                check(exp_sig(NB'(1) << a) != exp_sig(NB'(1) << b),
                      "R9 rows distinct", a, b);

        // R7: chain 0 error in last cycle -> tap vector, slice 0 first
        run_block(NB'(1) << ((D - 1) * NC), -1, got);
        run_block('0, -1, got);
        check(got == 5'b01011, "R7 serial order", got, 5'b01011);

        // R5: all-ones block leaves nothing behind
        run_block('1, -1, got);
        run_block('0, -1, got);
        run_block('0, -1, got);
        check(got == '0, "R5 cleared at boundary", got, 0);

        // R1: reset in mid run clears shadow and phase
        run_block('1, -1, got);
        run_block('0, 2, got);
        @(negedge clk);
        shift_en = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(tester_out == '0, "R1 out after mid reset", tester_out, 0);
        run_block('0, -1, got);
        check(got == '0, "R1 signature after mid reset", got, 0);

        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule